// File: doc/BRIEF.md
# Programmable periodic interrupt generator

This block raises a periodic interrupt from a 32.768 kHz time base. The 32 kHz time base arrives as a one-cycle tick enable in the fast system clock domain. A free-running 15-bit count advances on every tick. The block fires an event whenever that count lands on a whole multiple of the selected period. Events therefore fall on fixed, period-aligned boundaries of the running count. The count does not restart when an event fires or when the configuration changes.

A 4-bit rate code selects the period, which is 2^(code-1) ticks. Codes 1 and 2 are folded onto the slow rates of codes 8 and 9, and code 0 turns the generator off. A separate enable bit must also be set before any event can fire.

Each event sets a periodic flag and an interrupt summary flag, and drives the interrupt line high. Software reads the status, pulsing the read strobe for one cycle, and that read clears both flags. If an event and a read happen in the same cycle, the event takes priority.

Top module: `periodic_irq_gen`

## Requirements
- R1: After a synchronous active-low reset, the periodic flag, the summary flag and `irq` are 0, and the free-running count is 0.
- R2: The free-running count advances by one only in cycles where `tick_32k` is 1. No event fires in a cycle without a tick.
- R3: Rate code 0 produces no events, whatever the other inputs are.
- R4: With `per_en` at 0, no events fire for any rate code.
- R5: For codes 3 to 15, the period is 2^(code-1) ticks. For example, code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R6: Code 1 behaves as code 8, with a period of 128 ticks. Code 2 behaves as code 9, with a period of 256 ticks.
- R7: An event fires on a tick whose incremented count value is a multiple of the period. The count is 15 bits wide, so it wraps from 32767 to 0, and the tick that wraps it to 0 is an event for every code.
- R8: In the cycle after an event, `per_flag` and `irq_flag` are both 1, and `irq` equals `irq_flag` at all times.
- R9: A cycle with `stat_rd` at 1 and no event clears both flags and `irq` in the next cycle.
- R10: When an event and `stat_rd` fall in the same cycle, both flags are 1 in the next cycle.
- R11: A change to the rate code or to `per_en` takes effect on the very next tick. The next event follows the new period's alignment to the running count, and no restart takes place.
- R12: When there is no event and no read, the flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| rate_code | input | 4 | Period select: 0 means off, 1 and 2 fold to 8 and 9, otherwise the period is 2^(code-1) ticks |
| per_en | input | 1 | Periodic event enable |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| per_flag | output | 1 | Periodic event flag |
| irq_flag | output | 1 | Interrupt request summary flag |
| irq | output | 1 | Interrupt line, active high |

## Verification
On every cycle, the assertions check that no event fires without a tick, with code 0 or with the enable low. They also check that an event always leaves both flags set, that a plain read clears them, that the flags hold otherwise, and that `irq` tracks the summary flag. Only the bench's scenarios can show the timing that depends on the count itself. These are the exact tick on which events land for each code, the folded codes 1 and 2, the alignment after a mid-run rate change, and the wrap of the 15-bit count.

// File: rtl/pirq_pkg.sv
// Package: shared widths and helpers for the periodic interrupt generator.
// Assumes rate codes of four bits and a time-base count wide enough for
// the longest period.
package pirq_pkg;
    localparam int CODE_W = 4;

    // Fold the nonlinear codes 1 and 2 onto the slower codes 8 and 9.
    function automatic logic [CODE_W:0] fold_code(input logic [CODE_W-1:0] code);
        logic [CODE_W:0] c;
        c = {1'b0, code};
        if (code == 4'd1 || code == 4'd2) c = c + 5'd7;
        return c;
    endfunction
endpackage

// File: rtl/pirq_timebase.sv
// Module: free-running count of 32 kHz ticks.
// Assumes tick_en is a one-cycle pulse. The count wraps at 2^CNT_W and is
// never restarted by events or by configuration writes.
module pirq_timebase #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_next
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt_next = cnt_q + 1'b1;

    // Advance the count on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (tick_en) cnt_q <= cnt_next;
    end
endmodule

// File: rtl/pirq_rate_match.sv
// Module: decides whether the current tick ends a period.
// Assumes CNT_W >= 2^CODE_W - 2, so the longest period divides the count
// range exactly. Purely combinational.
module pirq_rate_match
    import pirq_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic              tick_en,
    input  logic              per_en,
    input  logic [CODE_W-1:0] rate_code,
    input  logic [CNT_W-1:0]  cnt_next,
    output logic              evt
);
    logic [CODE_W:0]  eff_code;
    logic [CNT_W-1:0] low_mask;

    assign eff_code = fold_code(rate_code);

    // Mask bit i is set when bit i lies below the period boundary
    // (period = 2^(eff_code-1)).
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign low_mask[i] = ((i + 1) < int'(eff_code));
    end

    // Event when enabled and the incremented count is period aligned.
    always_comb begin
        evt = 1'b0;
        if (tick_en && per_en && (rate_code != '0))
            evt = ((cnt_next & low_mask) == '0);
    end
endmodule

// File: rtl/pirq_status.sv
// Module: clear-on-read status flags for the periodic interrupt.
// Assumes a read strobe lasts one cycle. An event in the same cycle as a
// read wins.
module pirq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd,
    output logic per_flag,
    output logic sum_flag
);
    // Set on event, clear on read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_flag <= 1'b0;
            sum_flag <= 1'b0;
        end else if (evt) begin
            per_flag <= 1'b1;
            sum_flag <= 1'b1;
        end else if (rd) begin
            per_flag <= 1'b0;
            sum_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/periodic_irq_gen.sv
// Module: top of the programmable periodic interrupt generator.
// Counts 32 kHz ticks and raises flags and irq on period-aligned
// boundaries. Assumes synchronous inputs in the clk domain.
module periodic_irq_gen
    import pirq_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              per_en,
    input  logic              stat_rd,
    output logic              per_flag,
    output logic              irq_flag,
    output logic              irq
);
    logic [CNT_W-1:0] cnt_next;
    logic             evt;

    pirq_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_32k),
        .cnt_next (cnt_next)
    );

    pirq_rate_match #(.CNT_W(CNT_W)) u_match (
        .tick_en   (tick_32k),
        .per_en    (per_en),
        .rate_code (rate_code),
        .cnt_next  (cnt_next),
        .evt       (evt)
    );

    pirq_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .rd       (stat_rd),
        .per_flag (per_flag),
        .sum_flag (irq_flag)
    );

    assign irq = irq_flag;
endmodule

// File: rtl/pirq_checker.sv
// Module: assertion checker bound to periodic_irq_gen.
module pirq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_32k,
    input logic [3:0] rate_code,
    input logic       per_en,
    input logic       stat_rd,
    input logic       evt,
    input logic       per_flag,
    input logic       irq_flag,
    input logic       irq
);
    a_r2_no_tick_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_32k |-> !evt);
    a_r3_code_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == 4'd0) |-> !evt);
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !per_en |-> !evt);
    a_r8_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (per_flag && irq_flag));
    a_r8_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        irq == irq_flag);
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !evt) |=> (!per_flag && !irq_flag));
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && !evt) |=> ($stable(per_flag) && $stable(irq_flag)));
endmodule

bind periodic_irq_gen pirq_checker i_pirq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_32k  (tick_32k),
    .rate_code (rate_code),
    .per_en    (per_en),
    .stat_rd   (stat_rd),
    .evt       (evt),
    .per_flag  (per_flag),
    .irq_flag  (irq_flag),
    .irq       (irq)
);

// File: tb/test_periodic_irq_gen.sv
module test_periodic_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       per_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic       per_flag, irq_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    int  m_cnt = 0;
    bit  m_flag = 1'b0;

    always #5 clk = ~clk;

    periodic_irq_gen i_periodic_irq_gen (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
        .per_en(per_en), .stat_rd(stat_rd), .per_flag(per_flag),
        .irq_flag(irq_flag), .irq(irq)
    );

    // Behavioural reference: integer count, period from the code.
    always @(posedge clk) begin
        bit ev;
        int e;
        ev = 1'b0;
        if (!rst_n) begin
            m_cnt = 0;
            m_flag = 1'b0;
        end else begin
            if (tick_32k) begin
                m_cnt = (m_cnt + 1) % 32768;
                if (per_en && rate_code != 0) begin
                    e = (rate_code <= 2) ? rate_code + 7 : rate_code;
                    if (m_cnt % (1 << (e - 1)) == 0) ev = 1'b1;
                end
            end
            if (ev) m_flag = 1'b1;
            else if (stat_rd) m_flag = 1'b0;
        end
    end

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle (R8, R12 and all timing).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 per_flag vs model", per_flag, m_flag);
            check("R8 irq_flag vs model", irq_flag, m_flag);
            check("R8 irq tracks irq_flag", irq, irq_flag);
        end
    end

    task automatic step(logic t, logic r);
        tick_32k = t;
        stat_rd = r;
        @(posedge clk);
        #1;
        tick_32k = 1'b0;
        stat_rd = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 per_flag after reset", per_flag, 1'b0);
        check("R1 irq after reset", irq, 1'b0);

        // R5 code 3: period 4, event on 4th tick
        rate_code = 4'd3; per_en = 1'b1;
        ticks(3);
        check("R5 code3 before 4th tick", per_flag, 1'b0);
        ticks(1);
        check("R5 code3 at 4th tick", per_flag, 1'b1);
        // R12 hold over idle cycles
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
        check("R12 flag holds", per_flag, 1'b1);
        // R9 read clears
        step(1'b0, 1'b1);
        check("R9 read clears per_flag", per_flag, 1'b0);
        check("R9 read clears irq", irq, 1'b0);

        // R10 event and read together: count at 4, event at 8
        ticks(3);
        step(1'b1, 1'b1);
        check("R10 event wins over read", per_flag, 1'b1);
        step(1'b1, 1'b1);
        check("R10 later read clears", irq_flag, 1'b0);

        // R11 / R7: at count 6 switch code 3 -> 4; next event at count 8
        do_reset();
        rate_code = 4'd3;
        ticks(6);
        step(1'b0, 1'b1);
        rate_code = 4'd4;
        ticks(1);
        check("R11 no event at count 7", per_flag, 1'b0);
        ticks(1);
        check("R11 aligned event at count 8", per_flag, 1'b1);

        // R2 gapped ticks: event only after 4 ticks
        do_reset();
        rate_code = 4'd3;
        for (int i = 0; i < 3; i++) begin step(1'b1, 1'b0); step(1'b0, 1'b0); end
        check("R2 no event after 3 gapped ticks", per_flag, 1'b0);
        step(1'b1, 1'b0);
        check("R2 event on 4th gapped tick", per_flag, 1'b1);

        // R6 folded codes
        do_reset();
        rate_code = 4'd1;
        ticks(127);
        check("R6 code1 before 128", per_flag, 1'b0);
        ticks(1);
        check("R6 code1 at 128", per_flag, 1'b1);
        do_reset();
        rate_code = 4'd2;
        ticks(255);
        check("R6 code2 before 256", per_flag, 1'b0);
        ticks(1);
        check("R6 code2 at 256", per_flag, 1'b1);

        // R3 code zero
        do_reset();
        rate_code = 4'd0;
        ticks(300);
        check("R3 code0 silent", per_flag, 1'b0);

        // R4 enable off
        do_reset();
        rate_code = 4'd3; per_en = 1'b0;
        ticks(50);
        check("R4 disabled silent", irq, 1'b0);
        per_en = 1'b1;

        // R5 / R7 code 15 and 15-bit wrap
        do_reset();
        rate_code = 4'd15;
        ticks(16383);
        check("R5 code15 before 16384", per_flag, 1'b0);
        ticks(1);
        check("R5 code15 at 16384", per_flag, 1'b1);
        step(1'b0, 1'b1);
        ticks(16383);
        check("R7 no event before wrap", per_flag, 1'b0);
        ticks(1);
        check("R7 event on wrap to 0", per_flag, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule